// File: doc/BRIEF.md
# Clock Mode Switch Sequencer

This block moves a clock-control register from one setting to another without letting the core clock run from a source that has not settled yet. A 32-bit configuration word is either assembled from separate fields (PLL enable, crystal divisor, VCO multiplier, post-divisor, oscillator drive, source select) or taken as a ready-made word. The block then issues three register writes, one per clock cycle where no wait is needed. The first write is zero, which selects the internal fast RC clock. The second write is the configuration with the source bits forced to the fast RC value, so the oscillator and PLL start up while the core stays on the RC clock. After a programmable settling interval the third write applies the requested source.

The settling interval is a cycle count. At the default it covers roughly 10 ms at the fastest expected RC speed of 30 MHz. A configuration word whose upper spare bits are not all zero means "leave the clock alone": the block then makes no write and only reports completion. A separate combinational flag reports PLL settings whose VCO frequency (crystal / divisor × multiplier) falls outside the allowed window.

Top module: `clkcfg_sequencer`

## Requirements
- R1: In field mode the word carries the PLL enable in bit 24, the crystal divisor minus one in bits 23:18, the multiplier minus one in bits 17:8, the post-divider code in bits 7:4, the oscillator mode in bits 3:2 and the source select in bits 1:0. Bits 31:25 are zero.
- R2: The post-divider code is 4'b1111 for a divisor of 1. For an even divisor N from 2 to 30 it is N/2 − 1, so 2 gives 0 and 30 gives 14.
- R3: An accepted start produces exactly three writes on consecutive write strobes: first 32'h0, then the word with bits 1:0 cleared, then the full word. The first write occurs in the cycle after start is sampled, and the second follows it directly.
- R4: Exactly SETTLE_CYCLES cycles without a write separate the second and third writes.
- R5: In raw mode the third write equals the supplied raw word bit for bit.
- R6: A word with any of bits 31:25 set produces no write. done pulses in the cycle after start, and busy stays low.
- R7: busy is high from the first write through the final write and low otherwise. done is a one-cycle pulse in the cycle after the final write, with busy low.
- R8: A start, or a change of the inputs, while busy has no effect on the sequence in progress.
- R9: range_err_o is high exactly when the word's PLL enable bit is set and XTAL_HZ × (multiplier) / (divisor) is below 50 MHz or above VCO_MAX_HZ. Both bounds are inclusive as legal values.
- R10: After reset no write is issued, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| use_raw_i | input | 1 | 1 = use raw_word_i, 0 = assemble from fields |
| raw_word_i | input | 32 | Ready-made configuration word |
| pll_en_i | input | 1 | PLL enable field |
| xdiv_i | input | 7 | Crystal divisor, 1 to 64 |
| xmul_i | input | 11 | VCO multiplier, 1 to 1024 |
| pdiv_i | input | 5 | Post divisor: 1 or an even value 2 to 30 |
| osc_mode_i | input | 2 | 00 off, 01 external oscillator, 10 crystal 15 pF, 11 crystal 30 pF |
| src_sel_i | input | 2 | 00 fast RC, 01 slow RC, 10 crystal, 11 crystal through PLL |
| reg_we_o | output | 1 | Clock-control register write strobe |
| reg_data_o | output | 32 | Clock-control register write data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| range_err_o | output | 1 | VCO frequency out of range for the selected word |

## Verification
The assertions assume that start_i is a synchronous strobe, and that the divisor and multiplier inputs never take the value zero, because zero has no field encoding. The bench drives only legal divisors (1 to 4 in the range sweep, up to 16 in the word sweep) and post-divisors drawn from the legal set of 1 and the even values 2 to 30. It pulses start only from the negative clock edge, and it changes inputs during a running sequence only in the test that checks that such changes are ignored.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
   // Bit positions of the configuration word; a clock-control register decodes them.
   localparam int unsigned SRC_LSB   = 0;
   localparam int unsigned OSC_LSB   = 2;
   localparam int unsigned PDIV_LSB  = 4;
   localparam int unsigned MUL_LSB   = 8;
   localparam int unsigned DIV_LSB   = 18;
   localparam int unsigned PLLEN_BIT = 24;
   localparam int unsigned SPARE_LSB = 25;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned SRC_W  = 2;
   localparam int unsigned OSC_W  = 2;
   localparam int unsigned PDIV_W = 4;
   localparam int unsigned MUL_W  = 10;
   localparam int unsigned DIV_W  = 6;
   localparam int unsigned SPARE_W = WORD_W - SPARE_LSB;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RC,
      ST_PREP,
      ST_SETTLE,
      ST_APPLY,
      ST_FINISH
   } seq_state_e;
endpackage

// File: rtl/clkcfg_word_build.sv
module clkcfg_word_build
   import clkcfg_pkg::*;
(
   input  logic                 use_raw_i,
   input  logic [WORD_W-1:0]    raw_word_i,
   input  logic                 pll_en_i,
   input  logic [DIV_W:0]       xdiv_i,
   input  logic [MUL_W:0]       xmul_i,
   input  logic [4:0]           pdiv_i,
   input  logic [OSC_W-1:0]     osc_mode_i,
   input  logic [SRC_W-1:0]     src_sel_i,
   output logic [WORD_W-1:0]    word_o
);
   logic [DIV_W-1:0]  div_f;
   logic [MUL_W-1:0]  mul_f;
   logic [PDIV_W-1:0] pdiv_f;
   logic [WORD_W-1:0] built;
   logic [DIV_W:0]    div_m1;
   logic [MUL_W:0]    mul_m1;
   logic [PDIV_W-1:0] half;

   always_comb begin
      div_m1 = xdiv_i - 1'b1;
      mul_m1 = xmul_i - 1'b1;
      div_f  = div_m1[DIV_W-1:0];
      mul_f  = mul_m1[MUL_W-1:0];
      // divide-by-1 wraps to all ones, even N maps to N/2-1
      half   = pdiv_i[4:1];
      pdiv_f = half + 4'hF;
      built  = '0;
      built[PLLEN_BIT]                  = pll_en_i;
      built[DIV_LSB  +: DIV_W]          = div_f;
      built[MUL_LSB  +: MUL_W]          = mul_f;
      built[PDIV_LSB +: PDIV_W]         = pdiv_f;
      built[OSC_LSB  +: OSC_W]          = osc_mode_i;
      built[SRC_LSB  +: SRC_W]          = src_sel_i;
      word_o = use_raw_i ? raw_word_i : built;
   end
endmodule

// File: rtl/clkcfg_vco_check.sv
module clkcfg_vco_check
   import clkcfg_pkg::*;
#(
   parameter longint unsigned XTAL_HZ    = 64'd20_000_000,
   parameter longint unsigned VCO_MIN_HZ = 64'd50_000_000,
   parameter longint unsigned VCO_MAX_HZ = 64'd400_000_000,
   parameter bit              REG_OUT    = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_i,
   output logic              err_o
);
   localparam int unsigned PROD_W = 64;

   logic [PROD_W-1:0] xtal_x_mul;
   logic [PROD_W-1:0] min_x_div;
   logic [PROD_W-1:0] max_x_div;
   logic [MUL_W:0]    mult;
   logic [DIV_W:0]    divs;
   logic              err_c;

   always_comb begin
      mult = {1'b0, word_i[MUL_LSB +: MUL_W]} + 1'b1;
      divs = {1'b0, word_i[DIV_LSB +: DIV_W]} + 1'b1;
      // compare cross-multiplied to avoid a divider
      xtal_x_mul = PROD_W'(XTAL_HZ) * PROD_W'(mult);
      min_x_div  = PROD_W'(VCO_MIN_HZ) * PROD_W'(divs);
      max_x_div  = PROD_W'(VCO_MAX_HZ) * PROD_W'(divs);
      err_c = word_i[PLLEN_BIT] &&
              ((xtal_x_mul < min_x_div) || (xtal_x_mul > max_x_div));
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_o <= 1'b0;
            else        err_o <= err_c;
         end
      end else begin : g_comb
         assign err_o = err_c;
      end
   endgenerate
endmodule

// File: rtl/clkcfg_seq_ctrl.sv
module clkcfg_seq_ctrl
   import clkcfg_pkg::*;
#(
   parameter int unsigned SETTLE_CYCLES = 300_000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              reg_we_o,
   output logic [WORD_W-1:0] reg_data_o,
   output logic              busy_o,
   output logic              done_o
);
   localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

   seq_state_e        state_q, state_d;
   logic [WORD_W-1:0] cfg_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              skip_req;

   assign skip_req = |word_i[SPARE_LSB +: SPARE_W];

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (start_i) state_d = skip_req ? ST_FINISH : ST_RC;
         ST_RC:     state_d = ST_PREP;
         ST_PREP:   state_d = ST_SETTLE;
         ST_SETTLE: if (cnt_q == '0) state_d = ST_APPLY;
         ST_APPLY:  state_d = ST_FINISH;
         ST_FINISH: state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cfg_q   <= '0;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start_i) cfg_q <= word_i;
         if (state_q == ST_PREP)            cnt_q <= CNT_LOAD;
         else if (state_q == ST_SETTLE && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
   end

   always_comb begin
      reg_we_o   = 1'b0;
      reg_data_o = '0;
      unique case (state_q)
         ST_RC: begin
            reg_we_o   = 1'b1;
            reg_data_o = '0;
         end
         ST_PREP: begin
            reg_we_o   = 1'b1;
            reg_data_o = {cfg_q[WORD_W-1:SRC_W], {SRC_W{1'b0}}};
         end
         ST_APPLY: begin
            reg_we_o   = 1'b1;
            reg_data_o = cfg_q;
         end
         default: ;
      endcase
   end

   assign busy_o = (state_q == ST_RC) || (state_q == ST_PREP) ||
                   (state_q == ST_SETTLE) || (state_q == ST_APPLY);
   assign done_o = (state_q == ST_FINISH);
endmodule

// File: rtl/clkcfg_sequencer.sv
module clkcfg_sequencer
   import clkcfg_pkg::*;
#(
   parameter longint unsigned XTAL_HZ       = 64'd20_000_000,
   parameter longint unsigned VCO_MAX_HZ    = 64'd400_000_000,
   parameter int unsigned     SETTLE_CYCLES = 300_000,
   parameter bit              REG_RANGE_ERR = 1'b0
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        use_raw_i,
   input  logic [31:0] raw_word_i,
   input  logic        pll_en_i,
   input  logic [6:0]  xdiv_i,
   input  logic [10:0] xmul_i,
   input  logic [4:0]  pdiv_i,
   input  logic [1:0]  osc_mode_i,
   input  logic [1:0]  src_sel_i,
   output logic        reg_we_o,
   output logic [31:0] reg_data_o,
   output logic        busy_o,
   output logic        done_o,
   output logic        range_err_o
);
   localparam longint unsigned VCO_MIN_HZ = 64'd50_000_000;

   generate
      if (SETTLE_CYCLES < 1) begin : g_bad_settle
         $error("SETTLE_CYCLES must be at least 1");
      end
      if (VCO_MAX_HZ <= VCO_MIN_HZ) begin : g_bad_window
         $error("VCO_MAX_HZ must exceed the 50 MHz floor");
      end
      if (XTAL_HZ == 0) begin : g_bad_xtal
         $error("XTAL_HZ must be non-zero");
      end
   endgenerate

   logic [WORD_W-1:0] word;

   clkcfg_word_build u_build (
      .use_raw_i  (use_raw_i),
      .raw_word_i (raw_word_i),
      .pll_en_i   (pll_en_i),
      .xdiv_i     (xdiv_i),
      .xmul_i     (xmul_i),
      .pdiv_i     (pdiv_i),
      .osc_mode_i (osc_mode_i),
      .src_sel_i  (src_sel_i),
      .word_o     (word)
   );

   clkcfg_vco_check #(
      .XTAL_HZ    (XTAL_HZ),
      .VCO_MIN_HZ (VCO_MIN_HZ),
      .VCO_MAX_HZ (VCO_MAX_HZ),
      .REG_OUT    (REG_RANGE_ERR)
   ) u_vco (
      .clk    (clk),
      .rst_n  (rst_n),
      .word_i (word),
      .err_o  (range_err_o)
   );

   clkcfg_seq_ctrl #(
      .SETTLE_CYCLES (SETTLE_CYCLES)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .word_i     (word),
      .reg_we_o   (reg_we_o),
      .reg_data_o (reg_data_o),
      .busy_o     (busy_o),
      .done_o     (done_o)
   );
endmodule

// File: rtl/clkcfg_sequencer_chk.sv
module clkcfg_sequencer_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_we_o,
   input logic [31:0] reg_data_o,
   input logic        busy_o,
   input logic        done_o
);
   AST_FIRST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (reg_we_o && reg_data_o == 32'h0)); // R3

   AST_PREP_SRC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy_o) && reg_we_o) |=> (reg_we_o && reg_data_o[1:0] == 2'b00)); // R3

   AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !reg_we_o); // R7

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7

   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o); // R7

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R6
endmodule

bind clkcfg_sequencer clkcfg_sequencer_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_we_o   (reg_we_o),
   .reg_data_o (reg_data_o),
   .busy_o     (busy_o),
   .done_o     (done_o)
);

// File: tb/test_clkcfg_sequencer.sv
module test_clkcfg_sequencer;
   localparam int SETTLE = 5;
   localparam longint XTAL = 20_000_000;
   localparam longint VMAX = 400_000_000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        use_raw_i = 1'b0;
   logic [31:0] raw_word_i = '0;
   logic        pll_en_i = 1'b0;
   logic [6:0]  xdiv_i = 7'd1;
   logic [10:0] xmul_i = 11'd1;
   logic [4:0]  pdiv_i = 5'd1;
   logic [1:0]  osc_mode_i = '0;
   logic [1:0]  src_sel_i = '0;
   logic        reg_we_o;
   logic [31:0] reg_data_o;
   logic        busy_o, done_o, range_err_o;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk; // 50 MHz

   clkcfg_sequencer #(
      .XTAL_HZ(XTAL), .VCO_MAX_HZ(VMAX), .SETTLE_CYCLES(SETTLE), .REG_RANGE_ERR(1'b0)
   ) i_clkcfg_sequencer (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .use_raw_i(use_raw_i),
      .raw_word_i(raw_word_i), .pll_en_i(pll_en_i), .xdiv_i(xdiv_i), .xmul_i(xmul_i),
      .pdiv_i(pdiv_i), .osc_mode_i(osc_mode_i), .src_sel_i(src_sel_i),
      .reg_we_o(reg_we_o), .reg_data_o(reg_data_o), .busy_o(busy_o), .done_o(done_o),
      .range_err_o(range_err_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model_word(input bit pll, input int d, input int m,
                                              input int p, input int osc, input int src);
      int code;
      code = (p == 1) ? 15 : (p / 2 - 1);
      return (32'(pll) << 24) | (32'(d - 1) << 18) | (32'(m - 1) << 8) |
             (32'(code) << 4) | (32'(osc) << 2) | 32'(src);
   endfunction

   // Runs one sequence; exp_word is the final word, skip means no writes expected.
   // disturb: pulse start with other inputs while busy (R8).
   task automatic run_seq(input logic [31:0] exp_word, input bit skip, input bit disturb,
                          input string req);
      logic [31:0] wdat[4];
      int widx[4];
      int nw = 0;
      int done_cnt = 0;
      int done_at = -1;
      int busy_bad = 0;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 1; i <= 30; i++) begin
         if (disturb && i == 4) begin
            start_i = 1'b1; use_raw_i = 1'b1; raw_word_i = 32'h0100_0003;
            src_sel_i = 2'b01;
         end
         if (disturb && i == 5) start_i = 1'b0;
         #1;
         if (reg_we_o) begin
            if (nw < 4) begin wdat[nw] = reg_data_o; widx[nw] = i; end
            nw++;
            if (!busy_o) busy_bad++;
         end
         if (done_o) begin
            done_cnt++;
            if (done_at < 0) done_at = i;
            if (busy_o) busy_bad++;
         end
         if (skip && busy_o) busy_bad++;
         @(negedge clk);
      end
      if (skip) begin
         chk(nw == 0, {req, " R6 no writes"}, nw, 0);
         chk(done_at == 1, {req, " R6 done timing"}, done_at, 1);
         chk(busy_bad == 0, {req, " R6 busy low"}, busy_bad, 0);
      end else begin
         chk(nw == 3, {req, " R3 write count"}, nw, 3);
         if (nw == 3) begin
            chk(wdat[0] == 32'h0 && widx[0] == 1, {req, " R3 first write"}, wdat[0], 0);
            chk(wdat[1] == {exp_word[31:2], 2'b00} && widx[1] == 2, {req, " R3 second write"},
                wdat[1], {exp_word[31:2], 2'b00});
            chk(wdat[2] == exp_word, {req, " R1 R5 final write"}, wdat[2], exp_word);
            chk(widx[2] - widx[1] == SETTLE + 1, {req, " R4 settle gap"},
                widx[2] - widx[1], SETTLE + 1);
            chk(done_at == widx[2] + 1, {req, " R7 done after final"}, done_at, widx[2] + 1);
         end
         chk(done_cnt == 1, {req, " R7 single done"}, done_cnt, 1);
         chk(busy_bad == 0, {req, " R7 busy window"}, busy_bad, 0);
      end
   endtask

   initial begin : watchdog
      repeat (100_000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      #1;
      chk(!reg_we_o && !busy_o && !done_o, "R10 in reset", {reg_we_o, busy_o, done_o}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk(!reg_we_o && !busy_o && !done_o, "R10 after reset", {reg_we_o, busy_o, done_o}, 0);

      // R1 / R2 sweep: all post divisors, all source selects
      for (int i = 0; i < 16; i++) begin
         for (int s = 0; s < 4; s++) begin
            int p = (i == 0) ? 1 : 2 * i;
            use_raw_i = 1'b0;
            pll_en_i = i[0];
            xdiv_i = 7'(i + 1);
            xmul_i = 11'(i * 7 + 3);
            pdiv_i = 5'(p);
            osc_mode_i = 2'(i);
            src_sel_i = 2'(s);
            run_seq(model_word(i[0], i + 1, i * 7 + 3, p, i % 4, s), 1'b0, 1'b0, "R2 sweep");
         end
      end
      // extreme field values
      pll_en_i = 1'b1; xdiv_i = 7'd64; xmul_i = 11'd1024; pdiv_i = 5'd30;
      osc_mode_i = 2'b11; src_sel_i = 2'b11;
      run_seq(model_word(1, 64, 1024, 30, 3, 3), 1'b0, 1'b0, "R1 max fields");

      // R5 raw mode
      use_raw_i = 1'b1; raw_word_i = 32'h01AB_CDEF;
      run_seq(32'h01AB_CDEF, 1'b0, 1'b0, "R5 raw");
      raw_word_i = 32'h0000_0002;
      run_seq(32'h0000_0002, 1'b0, 1'b0, "R5 raw xtal");

      // R6 skip on spare bits (each spare bit)
      for (int b = 25; b < 32; b++) begin
         raw_word_i = (32'h1 << b) | 32'h0000_00F3;
         run_seq(32'h0, 1'b1, 1'b0, "R6 skip");
      end

      // R8 disturbance while busy
      use_raw_i = 1'b0; pll_en_i = 1'b1; xdiv_i = 7'd2; xmul_i = 11'd10; pdiv_i = 5'd2;
      osc_mode_i = 2'b10; src_sel_i = 2'b11;
      run_seq(model_word(1, 2, 10, 2, 2, 3), 1'b0, 1'b1, "R8 ignore start");
      @(negedge clk); #1;
      chk(!busy_o && !reg_we_o, "R8 no restart", {busy_o, reg_we_o}, 0);

      // R9 range sweep
      use_raw_i = 1'b0;
      for (int d = 1; d <= 4; d++) begin
         for (int m = 1; m <= 90; m++) begin
            real vco;
            bit exp_err;
            pll_en_i = 1'b1; xdiv_i = 7'(d); xmul_i = 11'(m);
            vco = real'(XTAL) * real'(m) / real'(d);
            exp_err = (vco < 50.0e6) || (vco > real'(VMAX));
            #1;
            chk(range_err_o == exp_err, "R9 range", range_err_o, exp_err);
            @(negedge clk);
         end
      end
      pll_en_i = 1'b0; xdiv_i = 7'd1; xmul_i = 11'd1;
      #1;
      chk(range_err_o == 1'b0, "R9 pll off", range_err_o, 0);
      use_raw_i = 1'b1; raw_word_i = 32'h0100_0000; // PLL on, div 1, mul 1 -> 20 MHz
      #1;
      chk(range_err_o == 1'b1, "R9 raw low vco", range_err_o, 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule